// File: doc/BRIEF.md
# I2C Command Slave with Status-First Reads

This block is the serial front end of a small peripheral that accepts short commands and returns up to two result bytes. It watches SCL and SDA with the system clock, cleans both lines with a synchronizer and a majority-free agreement filter, and recognises START, STOP, the address byte and the data bytes. A write carries a command byte, optionally followed by one argument byte. At STOP or at a repeated START, the write is handed to the core as a single-cycle strobe.

Every read returns a serial status byte first. Buffered result bytes follow only if the master keeps acknowledging. The core loads one or two result bytes through a load port, which raises the data-available flag. The flag drops only once the last buffered byte has been fully shifted out. A read that ends after the status byte leaves the buffer intact.

The SDA pin is modelled as an open-drain pull-down enable: `sda_oe` high pulls the line low.

Top module: `i2c_status_slave`

## Requirements
- R1: The slave acknowledges only the address byte 0x28 (write) and 0x29 (read), that is, 7-bit address 0x14 with the R/W bit in bit 0. Any other address is not acknowledged and produces no command.
- R2: A write of one or two bytes after the address is acknowledged byte by byte. At the following STOP or repeated START, `cmd_valid` pulses for exactly one cycle with the first byte on `cmd_byte`, the second on `cmd_data`, and `cmd_has_data` high only when two bytes arrived.
- R3: In a write, the third and any later byte is not acknowledged and does not alter the command delivered.
- R4: The first byte of every read is the status byte: bit 7 ready, bit 6 data-available, bit 5 two-byte indicator, bits 4..0 zero. All bytes go out MSB first.
- R5: Ready clears when the command byte is acknowledged and sets again on a `core_done` pulse.
- R6: A `load_valid` pulse stores `load_d1`/`load_d2`, sets data-available, and sets the two-byte indicator to `load_two`. The stored bytes follow the status byte in order.
- R7: Data-available and the two-byte indicator clear after the eighth bit of the last loaded byte is shifted out. A status-only read, or a read that stops before the last byte, leaves them set.
- R8: When data-available is clear, any byte read after the status byte is 0xFF, and the flags stay unchanged.
- R9: After the master NACKs a byte, the slave keeps SDA released through any further SCL pulses until STOP or START.
- R10: SCL pulses lasting fewer than three system clocks are ignored.
- R11: After reset, SDA is released, `cmd_valid` is low and the status byte reads 0x80.
- R12: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | Pull SDA low when high |
| core_done | input | 1 | Core finished the last command; sets ready |
| load_valid | input | 1 | Load result bytes into the output buffer |
| load_two | input | 1 | Two result bytes are loaded (else one) |
| load_d1 | input | 8 | First result byte |
| load_d2 | input | 8 | Second result byte |
| cmd_valid | output | 1 | One-cycle strobe for a received write |
| cmd_byte | output | 8 | Command byte |
| cmd_data | output | 8 | Argument byte |
| cmd_has_data | output | 1 | Argument byte present |

## Verification
The assertions assume that the core neither loads results during a read transaction nor pulses `core_done` between a command acknowledge and the STOP that ends that write. The bench meets this by loading and signalling done only while the bus is idle. They also assume that SCL stays low for many system clocks after each falling edge. Otherwise a data change on SDA would be taken as START or STOP. The bench master therefore holds every SCL phase for ten clocks and moves SDA only mid-low.

// File: rtl/i2c_status_slave.sv
module i2c_status_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h14,
  parameter int         FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       core_done,
  input  logic       load_valid,
  input  logic       load_two,
  input  logic [7:0] load_d1,
  input  logic [7:0] load_d2,
  output logic       cmd_valid,
  output logic [7:0] cmd_byte,
  output logic [7:0] cmd_data,
  output logic       cmd_has_data
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_TX, S_RACK, S_WAIT} st_t;

  logic [1:0]          scl_s, sda_s;
  logic [FILT_LEN-1:0] scl_h, sda_h;
  logic                scl_f, sda_f, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[FILT_LEN-2:0], scl_s[1]};
      sda_h <= {sda_h[FILT_LEN-2:0], sda_s[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_d <= scl_f;
      sda_d <= sda_f;
    end

  wire scl_rise = scl_f & ~scl_d;
  wire scl_fall = ~scl_f & scl_d;
  wire start_c  = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_c   = scl_f & scl_d & ~sda_d & sda_f;

  st_t        st;
  logic [7:0] shreg, cmd_q, dat_q, d1, d2;
  logic [3:0] bcnt;
  logic [1:0] wcnt, bidx;
  logic       is_read, ack_m, rdy, dav, two;

  wire [7:0] status   = {rdy, dav, two, 5'b0};
  wire [1:0] last_idx = two ? 2'd2 : 2'd1;
  wire [1:0] nidx     = (bidx == 2'd3) ? 2'd3 : bidx + 2'd1;
  wire [7:0] next_b   = (nidx == 2'd1 && dav) ? d1 :
                        (nidx == 2'd2 && dav && two) ? d2 : 8'hFF;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; shreg <= '0; cmd_q <= '0; dat_q <= '0; d1 <= '0; d2 <= '0;
      bcnt <= '0; wcnt <= '0; bidx <= '0; is_read <= 1'b0; ack_m <= 1'b0;
      rdy <= 1'b1; dav <= 1'b0; two <= 1'b0; sda_oe <= 1'b0;
      cmd_valid <= 1'b0; cmd_byte <= '0; cmd_data <= '0; cmd_has_data <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (core_done) rdy <= 1'b1;
      if (load_valid) begin
        dav <= 1'b1; two <= load_two; d1 <= load_d1; d2 <= load_d2;
      end
      if (start_c || stop_c) begin
        if (wcnt != 2'd0) begin
          cmd_valid    <= 1'b1;
          cmd_byte     <= cmd_q;
          cmd_data     <= dat_q;
          cmd_has_data <= (wcnt == 2'd2);
        end
        st     <= start_c ? S_ADDR : S_IDLE;
        bcnt   <= '0;
        wcnt   <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_f};
              bcnt  <= bcnt + 4'd1;
            end else if (scl_fall && bcnt == 4'd8) begin
              bcnt <= '0;
              if (shreg[7:1] == DEV_ADDR) begin
                sda_oe  <= 1'b1;
                is_read <= shreg[0];
                st      <= S_AACK;
              end else st <= S_IDLE;
            end
          end
          S_AACK: if (scl_fall) begin
            bcnt <= '0;
            if (is_read) begin
              bidx   <= '0;
              shreg  <= status;
              sda_oe <= ~status[7];
              st     <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_WDAT;
            end
          end
          S_WDAT: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_f};
              bcnt  <= bcnt + 4'd1;
            end else if (scl_fall && bcnt == 4'd8) begin
              bcnt <= '0;
              if (wcnt != 2'd2) begin
                sda_oe <= 1'b1;
                wcnt   <= wcnt + 2'd1;
                st     <= S_WACK;
                if (wcnt == 2'd0) begin
                  cmd_q <= shreg;
                  rdy   <= 1'b0;
                end else dat_q <= shreg;
              end else st <= S_IDLE;
            end
          end
          S_WACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= S_WDAT;
          end
          S_TX: begin
            if (scl_rise) bcnt <= bcnt + 4'd1;
            else if (scl_fall) begin
              if (bcnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= S_RACK;
                if (bidx != 2'd0 && dav && bidx == last_idx) begin
                  dav <= 1'b0;
                  two <= 1'b0;
                end
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) ack_m <= ~sda_f;
            else if (scl_fall) begin
              if (ack_m) begin
                bidx   <= nidx;
                shreg  <= next_b;
                sda_oe <= ~next_b[7];
                bcnt   <= '0;
                st     <= S_TX;
              end else st <= S_WAIT;
            end
          end
          default: ;
        endcase
      end
    end

  assert_cmd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  assert_ready_low_at_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !rdy);
  assert_load_sets_dav_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> dav);
  assert_no_spurious_dav_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dav && !load_valid) |=> !dav);
  assert_release_after_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> !sda_oe);
  assert_sda_moves_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f);
endmodule

// File: tb/i2c_status_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_status_slave_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic core_done = 1'b0, load_valid = 1'b0, load_two = 1'b0;
  logic [7:0] load_d1 = '0, load_d2 = '0;
  logic sda_oe, cmd_valid, cmd_has_data;
  logic [7:0] cmd_byte, cmd_data;
  wire  sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c_status_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .core_done(core_done), .load_valid(load_valid), .load_two(load_two),
    .load_d1(load_d1), .load_d2(load_d2), .cmd_valid(cmd_valid),
    .cmd_byte(cmd_byte), .cmd_data(cmd_data), .cmd_has_data(cmd_has_data));

  int n_chk = 0, n_fail = 0, n_cmd = 0, r12_viol = 0, r9_viol = 0;
  logic [7:0] cap_cmd, cap_dat;
  logic cap_has, prev_scl = 1'b1, prev_oe = 1'b0, watch_r9 = 1'b0;

  always @(negedge clk) begin
    if (cmd_valid) begin
      n_cmd++; cap_cmd = cmd_byte; cap_dat = cmd_data; cap_has = cmd_has_data;
    end
    if (rst_n && scl_m && prev_scl && sda_oe != prev_oe) r12_viol++;
    if (watch_r9 && sda_oe) r9_viol++;
    prev_scl = scl_m; prev_oe = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int glitch_bit, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (i == glitch_bit) begin
        tick(3); scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(Q-5);
      end else tick(Q);
      scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_line;
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; scl_m = 1'b0;
    end
    tick(Q); sda_m = ~give_ack; tick(Q);
    scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q); sda_m = 1'b1;
  endtask

  task automatic read_txn(input int n, output logic [7:0] s, output logic [7:0] a, output logic [7:0] c);
    logic ack;
    a = 8'h00; c = 8'h00;
    i2c_start; send_byte(8'h29, -1, ack);
    recv_byte(n > 1, s);
    if (n > 1) recv_byte(n > 2, a);
    if (n > 2) recv_byte(1'b0, c);
    i2c_stop;
  endtask

  task automatic status_only(output logic [7:0] s);
    logic [7:0] x, y;
    read_txn(1, s, x, y);
  endtask

  task automatic pulse_done;
    @(negedge clk) core_done = 1'b1; @(negedge clk) core_done = 1'b0; tick(2);
  endtask

  task automatic load(input logic t, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk) begin load_valid = 1'b1; load_two = t; load_d1 = a; load_d2 = b; end
    @(negedge clk) load_valid = 1'b0; tick(2);
  endtask

  task automatic t_reset;
    logic [7:0] s;
    chk("R11 sda_oe", {7'b0, sda_oe}, 8'h00);
    chk("R11 cmd_valid", {7'b0, cmd_valid}, 8'h00);
    status_only(s);
    chk("R11 R4 status after reset", s, 8'h80);
  endtask

  task automatic t_bad_addr;
    logic ack; int c0;
    c0 = n_cmd;
    i2c_start; send_byte(8'h50, -1, ack);
    chk("R1 foreign address ack", {7'b0, ack}, 8'h00);
    i2c_stop;
    chk("R1 no command", 8'(n_cmd - c0), 8'h00);
  endtask

  task automatic t_write_one;
    logic a0, a1; logic [7:0] s; int c0;
    c0 = n_cmd;
    i2c_start; send_byte(8'h28, -1, a0); send_byte(8'hA5, -1, a1); i2c_stop;
    chk("R1 write address ack", {7'b0, a0}, 8'h01);
    chk("R2 command ack", {7'b0, a1}, 8'h01);
    chk("R2 one strobe", 8'(n_cmd - c0), 8'h01);
    chk("R2 cmd_byte", cap_cmd, 8'hA5);
    chk("R2 has_data low", {7'b0, cap_has}, 8'h00);
    status_only(s);
    chk("R5 ready cleared", s, 8'h00);
    pulse_done;
    status_only(s);
    chk("R5 ready restored", s, 8'h80);
  endtask

  task automatic t_write_two;
    logic a0, a1, a2;
    i2c_start; send_byte(8'h28, -1, a0); send_byte(8'h3C, -1, a1); send_byte(8'h5A, -1, a2); i2c_stop;
    chk("R2 data ack", {7'b0, a2}, 8'h01);
    chk("R2 cmd_byte two", cap_cmd, 8'h3C);
    chk("R2 cmd_data", cap_dat, 8'h5A);
    chk("R2 has_data high", {7'b0, cap_has}, 8'h01);
    pulse_done;
  endtask

  task automatic t_write_three;
    logic a0, a1, a2, a3;
    i2c_start; send_byte(8'h28, -1, a0); send_byte(8'h11, -1, a1);
    send_byte(8'h22, -1, a2); send_byte(8'h33, -1, a3); i2c_stop;
    chk("R3 third byte nacked", {7'b0, a3}, 8'h00);
    chk("R3 cmd kept", cap_cmd, 8'h11);
    chk("R3 data kept", cap_dat, 8'h22);
    pulse_done;
  endtask

  task automatic t_rstart;
    logic a0, a1; logic [7:0] s; int c0;
    c0 = n_cmd;
    i2c_start; send_byte(8'h28, -1, a0); send_byte(8'h44, -1, a1);
    i2c_start; send_byte(8'h29, -1, a0); recv_byte(1'b0, s); i2c_stop;
    chk("R2 strobe at repeated start", 8'(n_cmd - c0), 8'h01);
    chk("R2 cmd at repeated start", cap_cmd, 8'h44);
    chk("R5 status in same transfer", s, 8'h00);
    pulse_done;
  endtask

  task automatic t_no_data;
    logic [7:0] s, a, c;
    read_txn(3, s, a, c);
    chk("R8 status", s, 8'h80);
    chk("R8 first byte FF", a, 8'hFF);
    chk("R8 second byte FF", c, 8'hFF);
    status_only(s);
    chk("R8 flags unchanged", s, 8'h80);
  endtask

  task automatic t_one_byte;
    logic [7:0] s, a, c;
    load(1'b0, 8'hC3, 8'h00);
    status_only(s);
    chk("R6 one byte status", s, 8'hC0);
    status_only(s);
    chk("R7 status-only keeps dav", s, 8'hC0);
    read_txn(2, s, a, c);
    chk("R4 R6 data MSB first", a, 8'hC3);
    status_only(s);
    chk("R7 dav cleared", s, 8'h80);
  endtask

  task automatic t_two_bytes;
    logic [7:0] s, a, c;
    load(1'b1, 8'h81, 8'h7E);
    read_txn(2, s, a, c);
    chk("R6 two byte status", s, 8'hE0);
    chk("R6 first byte", a, 8'h81);
    status_only(s);
    chk("R7 partial read keeps dav", s, 8'hE0);
    read_txn(3, s, a, c);
    chk("R6 second byte", c, 8'h7E);
    status_only(s);
    chk("R7 full read clears", s, 8'h80);
  endtask

  task automatic t_nack_release;
    logic ack; logic [7:0] s;
    load(1'b0, 8'h00, 8'h00);
    i2c_start; send_byte(8'h29, -1, ack); recv_byte(1'b0, s);
    watch_r9 = 1'b1;
    for (int k = 0; k < 9; k++) begin
      tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0;
    end
    tick(Q);
    watch_r9 = 1'b0;
    i2c_stop;
    chk("R9 released after nack", 8'(r9_viol), 8'h00);
    status_only(s);
    chk("R9 R7 extra clocks no read", s, 8'hC0);
    read_txn(2, s, s, s);
  endtask

  task automatic t_glitch;
    logic a0, a1;
    i2c_start; send_byte(8'h28, 3, a0); send_byte(8'h6B, 5, a1); i2c_stop;
    chk("R10 address ack despite glitch", {7'b0, a0}, 8'h01);
    chk("R10 command intact", cap_cmd, 8'h6B);
    pulse_done;
  endtask

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    t_reset;
    t_bad_addr;
    t_write_one;
    t_write_two;
    t_write_three;
    t_rstart;
    t_no_data;
    t_one_byte;
    t_two_bytes;
    t_nack_release;
    t_glitch;
    chk("R12 sda stable while scl high", 8'(r12_viol), 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule